// File: doc/BRIEF.md
# Flash Erase Command Sequence Decoder

This block sits behind the write port of a NOR-style flash command interface. It watches single-cycle write strobes, each with an address and a data byte, and recognises the six-write chip erase and sector erase command sequences. A chip erase is handed on to the erase engine at once. A sector erase opens an acceptance window during which further sector erase writes add sectors to a 19-bit bitmap. When the window runs out, the block hands the collected bitmap to the erase engine.

While an erase is running, the block turns suspend and resume writes into one-cycle request pulses for the engine. A write that breaks a sequence sends the decoder back to read mode. The window length is a parameter counted in clock cycles. Its default of 10000 cycles stands for 80 µs at 125 MHz.

Top module: `erase_cmd_decoder`

## Requirements
- R1: While reset is asserted, and on release, `erase_start`, `suspend_req` and `resume_req` are low, `erase_map` is zero and `cmd_idle` is high.
- R2: Six writes form a chip erase: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h. Only address bits [10:0] are compared. In the cycle after the sixth write, `erase_start` pulses with `erase_chip` high and `erase_map` all ones.
- R3: The same five leading writes, followed by 30h at any address, start a sector erase for the sector that holds that address. Sector layout on address bits [19:0]: sector 0 covers 00000h–03FFFh, sector 1 covers 04000h–05FFFh, sector 2 covers 06000h–07FFFh, sector 3 covers 08000h–0FFFFh, and sector 3+k covers k·10000h–k·10000h+FFFFh for k = 1..15. Bit i of `erase_map` is sector i.
- R4: The sector-erase `erase_start` pulse is seen exactly WINDOW_CYCLES cycles after the last write accepted in the window. Each 30h write or B0h write in the window restarts that count.
- R5: Sector erase writes in the window may arrive in any order and any number. `erase_map` then has exactly the selected bits set and `erase_chip` low.
- R6: In the window, a write whose data is neither 30h nor B0h cancels the request. `cmd_idle` is high in the next cycle, and no `erase_start` follows.
- R7: A wrong data byte, or a wrong address on an address-checked step, anywhere in the first six writes returns the decoder to read mode (`cmd_idle` high) with no pulse.
- R8: Once a sector erase has started, B0h at any address makes `suspend_req` pulse in the next cycle. Other writes, including a late 30h, produce no pulse and leave `erase_map` unchanged.
- R9: While suspended, 30h at any address makes `resume_req` pulse in the next cycle. F0h is ignored and `cmd_idle` stays low. Suspend and resume may repeat within one erase.
- R10: `erase_done` while erasing and not suspended returns the decoder to read mode in the next cycle.
- R11: During a chip erase, B0h produces no `suspend_req`.
- R12: Each of `erase_start`, `suspend_req` and `resume_req` lasts one cycle, and at most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| erase_done | input | 1 | Pulse from the erase engine when an erase has finished |
| erase_start | output | 1 | One-cycle erase request |
| erase_chip | output | 1 | High when the current request is a chip erase |
| erase_map | output | 19 | Sectors to erase, valid with `erase_start` |
| suspend_req | output | 1 | One-cycle suspend request |
| resume_req | output | 1 | One-cycle resume request |
| cmd_idle | output | 1 | High in read mode |

## Verification
A wrong sequence state shows up within one cycle of the next write. Either `cmd_idle` fails to drop or rise, or a pulse appears or goes missing in the cycle after that write. A fault in the window counter only shows at the end of the window, as an `erase_start` one or more cycles early or late. For that reason every sector-erase pulse is checked against the exact cycle worked out from the last accepted write. A wrong bitmap bit is seen only on the `erase_start` cycle, so each start is compared against the full expected map.

// File: rtl/erase_cmd_pkg.sv
package erase_cmd_pkg;

  localparam int NUM_SECT = 19;
  localparam int SECT_IDX_W = 5;

  localparam logic [7:0] CODE_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CODE_UNLOCK_B = 8'h55;
  localparam logic [7:0] CODE_SETUP    = 8'h80;
  localparam logic [7:0] CODE_CHIP     = 8'h10;
  localparam logic [7:0] CODE_SECTOR   = 8'h30;
  localparam logic [7:0] CODE_SUSPEND  = 8'hB0;
  localparam logic [7:0] CODE_RESUME   = 8'h30;

  localparam logic [11:0] ADDR_UNLOCK_A = 12'h555;
  localparam logic [11:0] ADDR_UNLOCK_B = 12'h2AA;

  typedef enum logic [3:0] {
    ST_READ,
    ST_UNL1,
    ST_UNL2,
    ST_SETUP,
    ST_UNL3,
    ST_UNL4,
    ST_WINDOW,
    ST_ERASING,
    ST_SUSPENDED
  } seq_state_e;

  // Non-uniform layout: four small sectors at the bottom, then 64 KiB sectors.
  function automatic logic [SECT_IDX_W-1:0] sector_of(input logic [19:0] a);
    logic [SECT_IDX_W-1:0] idx;
    if (a[19:16] != 4'd0)        idx = 5'd3 + {1'b0, a[19:16]};
    else if (a[15])              idx = 5'd3;
    else if (a[14:13] == 2'b11)  idx = 5'd2;
    else if (a[14:13] == 2'b10)  idx = 5'd1;
    else                         idx = 5'd0;
    return idx;
  endfunction

  // Count value loaded when the acceptance window (re)starts.
  function automatic int unsigned window_load(input int unsigned cycles);
    return cycles - 1;
  endfunction

endpackage

// File: rtl/erase_seq_fsm.sv
module erase_seq_fsm
  import erase_cmd_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int CMD_ADDR_BITS = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              window_expired,
  input  logic              erase_done,
  output seq_state_e        state,
  output logic              chip_mode,
  output logic              ev_first_sector,
  output logic              ev_more_sector,
  output logic              ev_window_touch,
  output logic              ev_chip_go,
  output logic              ev_sector_go,
  output logic              ev_suspend,
  output logic              ev_resume,
  output logic              ev_abort
);

  localparam logic [ADDR_W-1:0] CMD_MASK = ADDR_W'((64'd1 << CMD_ADDR_BITS) - 64'd1);
  localparam logic [ADDR_W-1:0] A_UNL_A  = ADDR_W'(ADDR_UNLOCK_A);
  localparam logic [ADDR_W-1:0] A_UNL_B  = ADDR_W'(ADDR_UNLOCK_B);

  seq_state_e state_nx;
  logic       at_a, at_b;

  assign at_a = (wr_addr & CMD_MASK) == (A_UNL_A & CMD_MASK);
  assign at_b = (wr_addr & CMD_MASK) == (A_UNL_B & CMD_MASK);

  always_comb begin
    state_nx        = state;
    ev_first_sector = 1'b0;
    ev_more_sector  = 1'b0;
    ev_window_touch = 1'b0;
    ev_chip_go      = 1'b0;
    ev_sector_go    = 1'b0;
    ev_suspend      = 1'b0;
    ev_resume       = 1'b0;
    ev_abort        = 1'b0;
    unique case (state)
      ST_READ: begin
        if (wr_en && at_a && wr_data == CODE_UNLOCK_A) state_nx = ST_UNL1;
      end
      ST_UNL1: begin
        if (wr_en) begin
          if (at_b && wr_data == CODE_UNLOCK_B) state_nx = ST_UNL2;
          else begin state_nx = ST_READ; ev_abort = 1'b1; end
        end
      end
      ST_UNL2: begin
        if (wr_en) begin
          if (at_a && wr_data == CODE_SETUP) state_nx = ST_SETUP;
          else begin state_nx = ST_READ; ev_abort = 1'b1; end
        end
      end
      ST_SETUP: begin
        if (wr_en) begin
          if (at_a && wr_data == CODE_UNLOCK_A) state_nx = ST_UNL3;
          else begin state_nx = ST_READ; ev_abort = 1'b1; end
        end
      end
      ST_UNL3: begin
        if (wr_en) begin
          if (at_b && wr_data == CODE_UNLOCK_B) state_nx = ST_UNL4;
          else begin state_nx = ST_READ; ev_abort = 1'b1; end
        end
      end
      ST_UNL4: begin
        if (wr_en) begin
          if (at_a && wr_data == CODE_CHIP) begin
            state_nx   = ST_ERASING;
            ev_chip_go = 1'b1;
          end else if (wr_data == CODE_SECTOR) begin
            state_nx        = ST_WINDOW;
            ev_first_sector = 1'b1;
          end else begin
            state_nx = ST_READ;
            ev_abort = 1'b1;
          end
        end
      end
      ST_WINDOW: begin
        if (wr_en) begin
          if (wr_data == CODE_SECTOR) begin
            ev_more_sector  = 1'b1;
            ev_window_touch = 1'b1;
          end else if (wr_data == CODE_SUSPEND) begin
            ev_window_touch = 1'b1;
          end else begin
            state_nx = ST_READ;
            ev_abort = 1'b1;
          end
        end else if (window_expired) begin
          state_nx     = ST_ERASING;
          ev_sector_go = 1'b1;
        end
      end
      ST_ERASING: begin
        if (erase_done) state_nx = ST_READ;
        else if (wr_en && wr_data == CODE_SUSPEND && !chip_mode) begin
          state_nx   = ST_SUSPENDED;
          ev_suspend = 1'b1;
        end
      end
      ST_SUSPENDED: begin
        if (wr_en && wr_data == CODE_RESUME) begin
          state_nx  = ST_ERASING;
          ev_resume = 1'b1;
        end
      end
      default: state_nx = ST_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_READ;
      chip_mode <= 1'b0;
    end else begin
      state <= state_nx;
      if (ev_chip_go)           chip_mode <= 1'b1;
      else if (ev_first_sector) chip_mode <= 1'b0;
    end
  end

endmodule

// File: rtl/erase_window_timer.sv
module erase_window_timer
  import erase_cmd_pkg::*;
#(
  parameter int WINDOW_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic run,
  output logic expired
);

  localparam int CNT_W = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(window_load(WINDOW_CYCLES));

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                          cnt <= '0;
    else if (arm)                        cnt <= LOAD;
    else if (run && cnt != '0)           cnt <= cnt - 1'b1;
  end

  assign expired = run && (cnt == '0);

endmodule

// File: rtl/erase_sector_accum.sv
module erase_sector_accum #(
  parameter int NUM_SECT = 19,
  parameter int IDX_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                add,
  input  logic                fill,
  input  logic [IDX_W-1:0]    idx,
  output logic [NUM_SECT-1:0] map
);

  for (genvar i = 0; i < NUM_SECT; i++) begin : g_bit
    logic hit;
    assign hit = add && (idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)      map[i] <= 1'b0;
      else if (fill)   map[i] <= 1'b1;
      else if (clr)    map[i] <= hit;
      else if (hit)    map[i] <= 1'b1;
    end
  end

endmodule

// File: rtl/erase_cmd_decoder.sv
module erase_cmd_decoder
  import erase_cmd_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int CMD_ADDR_BITS = 11,
  parameter int WINDOW_CYCLES = 10000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  input  logic                erase_done,
  output logic                erase_start,
  output logic                erase_chip,
  output logic [NUM_SECT-1:0] erase_map,
  output logic                suspend_req,
  output logic                resume_req,
  output logic                cmd_idle
);

  seq_state_e            state;
  logic                  chip_mode;
  logic                  ev_first_sector, ev_more_sector, ev_window_touch;
  logic                  ev_chip_go, ev_sector_go, ev_suspend, ev_resume, ev_abort;
  logic                  window_expired;
  logic                  window_arm, window_run;
  logic [SECT_IDX_W-1:0] sector_idx;

  assign sector_idx = sector_of(wr_addr[19:0]);
  assign window_arm = ev_first_sector | ev_window_touch;
  assign window_run = (state == ST_WINDOW);

  erase_seq_fsm #(
    .ADDR_W        (ADDR_W),
    .CMD_ADDR_BITS (CMD_ADDR_BITS)
  ) seq_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (wr_en),
    .wr_addr         (wr_addr),
    .wr_data         (wr_data),
    .window_expired  (window_expired),
    .erase_done      (erase_done),
    .state           (state),
    .chip_mode       (chip_mode),
    .ev_first_sector (ev_first_sector),
    .ev_more_sector  (ev_more_sector),
    .ev_window_touch (ev_window_touch),
    .ev_chip_go      (ev_chip_go),
    .ev_sector_go    (ev_sector_go),
    .ev_suspend      (ev_suspend),
    .ev_resume       (ev_resume),
    .ev_abort        (ev_abort)
  );

  erase_window_timer #(
    .WINDOW_CYCLES (WINDOW_CYCLES)
  ) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (window_arm),
    .run     (window_run),
    .expired (window_expired)
  );

  erase_sector_accum #(
    .NUM_SECT (NUM_SECT),
    .IDX_W    (SECT_IDX_W)
  ) accum_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ev_first_sector | ev_chip_go),
    .add   (ev_first_sector | ev_more_sector),
    .fill  (ev_chip_go),
    .idx   (sector_idx),
    .map   (erase_map)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      erase_start <= 1'b0;
      suspend_req <= 1'b0;
      resume_req  <= 1'b0;
    end else begin
      erase_start <= ev_chip_go | ev_sector_go;
      suspend_req <= ev_suspend;
      resume_req  <= ev_resume;
    end
  end

  assign erase_chip = chip_mode;
  assign cmd_idle   = (state == ST_READ);

endmodule

// File: rtl/erase_cmd_checker.sv
module erase_cmd_checker #(
  parameter int WINDOW_CYCLES = 10000,
  parameter int NUM_SECT      = 19
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [7:0]          wr_data,
  input logic                erase_start,
  input logic                erase_chip,
  input logic [NUM_SECT-1:0] erase_map,
  input logic                suspend_req,
  input logic                resume_req,
  input logic                cmd_idle,
  input logic                window_expired
);

  localparam int QW = $clog2(WINDOW_CYCLES + 2) + 1;
  localparam logic [QW-1:0] QMAX = '1;

  logic [QW-1:0] quiet_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                quiet_cnt <= '0;
    else if (wr_en)            quiet_cnt <= '0;
    else if (quiet_cnt != QMAX) quiet_cnt <= quiet_cnt + 1'b1;
  end

  assert_start_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  assert_pulses_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_start, suspend_req, resume_req}));

  assert_chip_map_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_start && erase_chip) |-> (&erase_map));

  assert_sector_map_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (erase_map != '0));

  assert_window_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    window_expired |-> (quiet_cnt == QW'(WINDOW_CYCLES - 1)));

  assert_expiry_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (window_expired && !wr_en) |=> erase_start);

  assert_suspend_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |-> $past(wr_en && wr_data == 8'hB0));

  assert_resume_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> $past(wr_en && wr_data == 8'h30));

  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_idle && wr_en && wr_data != 8'hAA) |=> cmd_idle);

endmodule

bind erase_cmd_decoder erase_cmd_checker #(
  .WINDOW_CYCLES (WINDOW_CYCLES),
  .NUM_SECT      (erase_cmd_pkg::NUM_SECT)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_en          (wr_en),
  .wr_data        (wr_data),
  .erase_start    (erase_start),
  .erase_chip     (erase_chip),
  .erase_map      (erase_map),
  .suspend_req    (suspend_req),
  .resume_req     (resume_req),
  .cmd_idle       (cmd_idle),
  .window_expired (window_expired)
);

// File: tb/erase_cmd_decoder_tb_top.sv
module erase_cmd_decoder_tb_top;

  localparam int W = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        erase_done = 1'b0;
  logic        erase_start, erase_chip, suspend_req, resume_req, cmd_idle;
  logic [18:0] erase_map;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int last_n = 0;

  typedef struct {
    int          kind;   // 0 start, 1 suspend, 2 resume
    logic [18:0] map;
    bit          chip;
    int          at;
    string       req;
  } exp_t;

  exp_t sbq[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  erase_cmd_decoder #(
    .ADDR_W        (20),
    .CMD_ADDR_BITS (11),
    .WINDOW_CYCLES (W)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .erase_done  (erase_done),
    .erase_start (erase_start),
    .erase_chip  (erase_chip),
    .erase_map   (erase_map),
    .suspend_req (suspend_req),
    .resume_req  (resume_req),
    .cmd_idle    (cmd_idle)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic int bsect(input logic [19:0] a);
    if (a >= 20'h10000) return 3 + int'(a / 20'h10000);
    if (a >= 20'h08000) return 3;
    if (a >= 20'h06000) return 2;
    if (a >= 20'h04000) return 1;
    return 0;
  endfunction

  task automatic wr(input logic [19:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    last_n = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lead5();
    wr(20'h00555, 8'hAA); wr(20'h002AA, 8'h55); wr(20'h00555, 8'h80);
    wr(20'h00555, 8'hAA); wr(20'h002AA, 8'h55);
  endtask

  task automatic push(input int kind, input logic [18:0] m, input bit chip,
                      input int at, input string req);
    exp_t e;
    e.kind = kind; e.map = m; e.chip = chip; e.at = at; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic pulse_done();
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
  endtask

  // Monitor: compares every produced pulse against the scoreboard.
  always @(negedge clk) begin : monitor
    exp_t e;
    int   kind;
    #1;
    if (rst_n && (erase_start || suspend_req || resume_req)) begin
      kind = erase_start ? 0 : (suspend_req ? 1 : 2);
      if (sbq.size() == 0) begin
        chk(1'b0, "R12", "unexpected pulse kind", kind, -1);
      end else begin
        e = sbq.pop_front();
        chk(kind == e.kind, e.req, "pulse kind", kind, e.kind);
        chk(cyc == e.at, e.req, "pulse cycle", cyc, e.at);
        if (e.kind == 0) begin
          chk(erase_map == e.map, e.req, "erase_map", erase_map, e.map);
          chk(erase_chip == e.chip, e.req, "erase_chip", erase_chip, e.chip);
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL R12 watchdog expired: actual %0d expected %0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin : driver
    logic [18:0] m;
    idle(3);
    // R1 reset state
    chk(!erase_start && !suspend_req && !resume_req, "R1", "pulses in reset",
        {erase_start, suspend_req, resume_req}, 0);
    chk(erase_map == '0, "R1", "map in reset", erase_map, 0);
    chk(cmd_idle, "R1", "cmd_idle in reset", cmd_idle, 1);
    rst_n = 1'b1;
    idle(2);
    chk(cmd_idle, "R1", "cmd_idle after reset", cmd_idle, 1);

    // R2 chip erase, R11 suspend ignored, R10 done
    lead5();
    wr(20'hFF555, 8'h10);
    push(0, '1, 1'b1, last_n, "R2");
    idle(3);
    wr(20'h00000, 8'hB0);
    idle(3);
    chk(!cmd_idle, "R11", "still erasing after B0", cmd_idle, 0);
    pulse_done();
    chk(cmd_idle, "R10", "idle after done", cmd_idle, 1);

    // R3/R4 single sector
    lead5();
    wr(20'h34567, 8'h30);
    m = '0; m[bsect(20'h34567)] = 1'b1;
    push(0, m, 1'b0, last_n + W, "R3");
    idle(W + 3);
    pulse_done();

    // R5/R4 multiple sectors, restarts, B0 inside window
    lead5();
    wr(20'hF0000, 8'h30); idle(W / 2);
    wr(20'h05000, 8'h30); idle(W - 3);
    wr(20'h00010, 8'h30); idle(W / 3);
    wr(20'h07FFF, 8'h30); idle(W - 2);
    wr(20'h12345, 8'hB0);
    m = '0;
    m[bsect(20'hF0000)] = 1'b1; m[bsect(20'h05000)] = 1'b1;
    m[bsect(20'h00010)] = 1'b1; m[bsect(20'h07FFF)] = 1'b1;
    push(0, m, 1'b0, last_n + W, "R5");
    idle(W + 2);

    // R8 late sector ignored, R9 suspend/resume twice, F0 ignored
    wr(20'h20000, 8'h30);
    idle(2);
    chk(erase_map == m, "R8", "map after late 30h", erase_map, m);
    wr(20'h00000, 8'hB0); push(1, '0, 1'b0, last_n, "R8");
    idle(2);
    wr(20'h00555, 8'hF0);
    chk(!cmd_idle, "R9", "F0 ignored while suspended", cmd_idle, 0);
    wr(20'h00001, 8'h30); push(2, '0, 1'b0, last_n, "R9");
    idle(2);
    wr(20'h77777, 8'hB0); push(1, '0, 1'b0, last_n, "R9");
    wr(20'h00002, 8'h30); push(2, '0, 1'b0, last_n, "R9");
    idle(2);
    pulse_done();
    chk(cmd_idle, "R10", "idle after sector done", cmd_idle, 1);

    // R6 cancel in window
    lead5();
    wr(20'h40000, 8'h30);
    idle(5);
    wr(20'h00555, 8'hF0);
    chk(cmd_idle, "R6", "idle after cancel", cmd_idle, 1);
    idle(W + 5);

    // R7 broken sequences
    wr(20'h00555, 8'hAA); wr(20'h002AB, 8'h55);
    chk(cmd_idle, "R7", "idle after bad address", cmd_idle, 1);
    wr(20'h00555, 8'hAA); wr(20'h002AA, 8'h55); wr(20'h00555, 8'h81);
    chk(cmd_idle, "R7", "idle after bad setup", cmd_idle, 1);
    lead5(); wr(20'h00555, 8'h20);
    chk(cmd_idle, "R7", "idle after bad final byte", cmd_idle, 1);
    idle(W + 5);

    chk(sbq.size() == 0, "R12", "scoreboard drained", sbq.size(), 0);
    summary();
    $finish;
  end

endmodule